// File: doc/BRIEF.md
# Registered-Output Stream Buffer

This block is a single-clock, first-in first-out buffer placed between a producer and a consumer that both use a valid/ready handshake. It holds beats in arrival order and lets the two sides run at different instantaneous rates. A producer can push a burst while the consumer stalls, and the consumer can keep draining while the producer pauses.

The output port is driven from flip-flops. `m_valid` and `m_data` never depend combinationally on the storage empty comparison. A holding register in front of the output is refilled from storage whenever it is empty or being drained, so a continuous stream still moves at one beat per clock. When both storage and the holding register are empty, an incoming beat is written straight into the holding register. It then becomes visible one clock after it is accepted.

Storage depth `DEPTH` (a power of two, at least 2) and beat width `WIDTH` are parameters. The capacity seen at the input is `DEPTH + 1` beats: the storage entries plus the holding register.

Top module: `stream_buffer_ro`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the buffer empties. After reset `m_valid` is 0 and `s_ready` is 1.
- R2: `s_ready` is 0 exactly when the buffer holds `DEPTH + 1` beats, and 1 otherwise. A beat is accepted on a cycle where `s_valid` and `s_ready` are both 1.
- R3: `m_valid` is 1 exactly when the buffer holds at least one beat. A beat is removed on a cycle where `m_valid` and `m_ready` are both 1.
- R4: Beats appear on `m_data` in exactly the order they were accepted, with no loss and no duplication.
- R5: While `m_valid` is 1 and `m_ready` is 0, `m_valid` and `m_data` stay unchanged on the next cycle.
- R6: With `s_valid` and `m_ready` held at 1, one beat is accepted and one beat is delivered on every cycle, with no bubbles.
- R7: A beat accepted while the buffer is empty is presented on `m_valid`/`m_data` on the very next cycle.
- R8: With `m_ready` held at 0, exactly `DEPTH + 1` beats are accepted before `s_ready` falls.
- R9: A beat offered while `s_ready` is 0 is not stored. Later drains deliver only the accepted beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | WIDTH | Incoming beat |
| s_valid | input | 1 | Producer offers `s_data` |
| s_ready | output | 1 | Buffer can accept a beat this cycle |
| m_data | output | WIDTH | Oldest buffered beat, registered |
| m_valid | output | 1 | `m_data` holds a beat, registered |
| m_ready | input | 1 | Consumer takes the beat this cycle |

## Verification
The assertions assume the producer holds `s_data` stable only by its own choice. They do not assume that the producer keeps `s_valid` asserted until acceptance, nor that the consumer raises `m_ready` at any particular time. The bench therefore draws `s_valid`, `s_data` and `m_ready` independently each cycle, including offers made while `s_ready` is low. The occupancy counter in the checker is built only from handshakes seen at the ports, so it needs no assumption beyond a clean reset. The random phases change the rates on the two sides so that the buffer runs full, empty and in between. Directed phases cover the fill-to-capacity, bypass-latency and full-rate streaming cases.

// File: rtl/stream_buffer_pkg.sv
package stream_buffer_pkg;

    // Where the output holding register takes its next value from.
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,  // keep current beat (stalled)
        SRC_STORE  = 2'd1,  // oldest storage entry
        SRC_BYPASS = 2'd2,  // beat accepted this cycle, storage empty
        SRC_NONE   = 2'd3   // nothing available, go empty
    } out_src_e;

    function automatic int addr_bits(input int depth);
        return (depth > 2) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/sb_store.sv
module sb_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = stream_buffer_pkg::addr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] entry_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) begin
                entry_q[i] <= wdata;
            end
        end
    end

    assign rdata = entry_q[raddr];

endmodule

// File: rtl/sb_ptrs.sv
module sb_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = stream_buffer_pkg::addr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full,
    output logic          empty
);

    // Pointers carry one wrap bit above the address.
    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] rd;
    } ptr_state_t;

    ptr_state_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.wr = ptr_q.wr + 1'b1;
        end
        if (pop) begin
            ptr_d.rd = ptr_q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign waddr = ptr_q.wr[AW-1:0];
    assign raddr = ptr_q.rd[AW-1:0];
    assign empty = (ptr_q.wr == ptr_q.rd);
    assign full  = (ptr_q.wr[AW] != ptr_q.rd[AW]) &&
                   (ptr_q.wr[AW-1:0] == ptr_q.rd[AW-1:0]);

endmodule

// File: rtl/sb_outreg.sv
module sb_outreg
    import stream_buffer_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store_empty,
    input  logic [WIDTH-1:0] store_data,
    input  logic             in_fire,
    input  logic [WIDTH-1:0] in_data,
    input  logic             m_ready,
    output logic             pop,
    output logic             bypass,
    output logic             m_valid,
    output logic [WIDTH-1:0] m_data
);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
    } out_state_t;

    out_state_t out_d, out_q;
    out_src_e   src;
    logic       load;

    always_comb begin
        load = !out_q.valid || m_ready;
        if (!load) begin
            src = SRC_HOLD;
        end else if (!store_empty) begin
            src = SRC_STORE;
        end else if (in_fire) begin
            src = SRC_BYPASS;
        end else begin
            src = SRC_NONE;
        end

        out_d = out_q;
        unique case (src)
            SRC_STORE:  out_d = '{valid: 1'b1, data: store_data};
            SRC_BYPASS: out_d = '{valid: 1'b1, data: in_data};
            SRC_NONE:   out_d.valid = 1'b0;
            default:    out_d = out_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.valid <= 1'b0;
        end else begin
            out_q.valid <= out_d.valid;
        end
        out_q.data <= out_d.data;
    end

    assign pop     = (src == SRC_STORE);
    assign bypass  = (src == SRC_BYPASS);
    assign m_valid = out_q.valid;
    assign m_data  = out_q.data;

endmodule

// File: rtl/stream_buffer_ro.sv
module stream_buffer_ro #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic [WIDTH-1:0] m_data,
    output logic             m_valid,
    input  logic             m_ready
);

    localparam int AW = stream_buffer_pkg::addr_bits(DEPTH);

    logic [AW-1:0]    waddr, raddr;
    logic [WIDTH-1:0] rdata;
    logic             full, empty, push, pop, bypass, in_fire;

    assign s_ready = !full;
    assign in_fire = s_valid && !full;
    assign push    = in_fire && !bypass;

    sb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .waddr (waddr),
        .raddr (raddr),
        .full  (full),
        .empty (empty)
    );

    sb_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (waddr),
        .wdata (s_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    sb_outreg #(.WIDTH(WIDTH)) u_out (
        .clk         (clk),
        .rst         (rst),
        .store_empty (empty),
        .store_data  (rdata),
        .in_fire     (in_fire),
        .in_data     (s_data),
        .m_ready     (m_ready),
        .pop         (pop),
        .bypass      (bypass),
        .m_valid     (m_valid),
        .m_data      (m_data)
    );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] s_data,
    input logic             s_valid,
    input logic             s_ready,
    input logic [WIDTH-1:0] m_data,
    input logic             m_valid,
    input logic             m_ready
);

    localparam int CAP = DEPTH + 1;
    localparam int CW  = $clog2(CAP + 1) + 1;

    logic [CW-1:0] occ_q;
    logic          in_hs, out_hs;

    assign in_hs  = s_valid && s_ready;
    assign out_hs = m_valid && m_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CW'(in_hs) - CW'(out_hs);
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (!m_valid && s_ready)); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (occ_q <= CW'(CAP)) && (s_ready == (occ_q < CW'(CAP)))); // R2

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
        m_valid == (occ_q != '0)); // R3

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R5

    AST_STREAM_FLOW: assert property (@(posedge clk) disable iff (rst)
        (in_hs && out_hs) |=> m_valid); // R6

    AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (rst)
        (in_hs && !m_valid) |=> m_valid); // R7

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!s_ready && !m_ready) |=> !s_ready); // R9

endmodule

bind stream_buffer_ro sb_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_data  (s_data),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .m_data  (m_data),
    .m_valid (m_valid),
    .m_ready (m_ready)
);

// File: tb/tb_stream_buffer_ro.sv
module tb_stream_buffer_ro;

    localparam int WIDTH = 8;
    localparam int DEPTH = 4;
    localparam int CAP   = DEPTH + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] s_data = '0;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [WIDTH-1:0] m_data;
    logic             m_valid;
    logic             m_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [WIDTH-1:0] model_q[$];
    logic             prev_stall = 1'b0;
    logic [WIDTH-1:0] prev_data  = '0;
    int               in_cnt, out_cnt;

    always #2.5 clk = ~clk;

    stream_buffer_ro #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid),
        .s_ready(s_ready), .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_ready();
        return model_q.size() < CAP;
    endfunction

    // Compare outputs against the model; called away from the clock edge.
    task automatic check_outputs();
        chk(s_ready == exp_ready(), "R2 s_ready", int'(s_ready), int'(exp_ready()));
        chk(m_valid == (model_q.size() > 0), "R3 m_valid", int'(m_valid),
            int'(model_q.size() > 0));
        if (m_valid && model_q.size() > 0) begin
            chk(m_data == model_q[0], "R4 order", int'(m_data), int'(model_q[0]));
        end
        if (prev_stall) begin
            chk(m_valid && m_data == prev_data, "R5 stall hold", int'(m_data), int'(prev_data));
        end
    endtask

    // One cycle: drive at negedge, update model from the handshakes, check next negedge.
    task automatic cycle(input bit sv, input logic [WIDTH-1:0] sd, input bit mr);
        bit in_hs, out_hs;
        s_valid = sv;
        s_data  = sd;
        m_ready = mr;
        in_hs  = sv && s_ready;
        out_hs = m_valid && mr;
        prev_stall = m_valid && !mr;
        prev_data  = m_data;
        if (out_hs) begin
            void'(model_q.pop_front());
            out_cnt++;
        end
        if (in_hs) begin
            model_q.push_back(sd);
            in_cnt++;
        end
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic drain_all();
        for (int i = 0; i < 3 * CAP && model_q.size() > 0; i++) begin
            cycle(1'b0, '0, 1'b1);
        end
        chk(model_q.size() == 0 && !m_valid, "R3 drained", int'(m_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        chk(!m_valid, "R1 m_valid after reset", int'(m_valid), 0);
        chk(s_ready, "R1 s_ready after reset", int'(s_ready), 1);

        // R7: single beat into an empty buffer visible next cycle
        cycle(1'b1, 8'hA5, 1'b0);
        chk(m_valid && m_data == 8'hA5, "R7 bypass latency", int'(m_data), 8'hA5);
        drain_all();

        // R8 and R9: fill with consumer stalled, keep offering past capacity
        in_cnt = 0;
        for (int i = 0; i < CAP + 4; i++) begin
            cycle(1'b1, WIDTH'(8'h10 + i), 1'b0);
        end
        chk(in_cnt == CAP, "R8 capacity", in_cnt, CAP);
        chk(!s_ready, "R9 full rejects", int'(s_ready), 0);
        out_cnt = 0;
        drain_all();
        chk(out_cnt == CAP, "R9 only accepted beats delivered", out_cnt, CAP);

        // R6: full-rate streaming, one in and one out every cycle
        cycle(1'b1, 8'h40, 1'b1);
        in_cnt = 0;
        out_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            cycle(1'b1, WIDTH'(8'h41 + i), 1'b1);
        end
        chk(in_cnt == 20, "R6 accepted per cycle", in_cnt, 20);
        chk(out_cnt == 20, "R6 delivered per cycle", out_cnt, 20);
        drain_all();

        // Random phases with shifting producer/consumer rates (R2, R3, R4, R5)
        for (int phase = 0; phase < 4; phase++) begin
            int pv = (phase == 0) ? 90 : (phase == 1) ? 30 : (phase == 2) ? 60 : 75;
            int pr = (phase == 0) ? 30 : (phase == 1) ? 90 : (phase == 2) ? 60 : 50;
            for (int i = 0; i < 500; i++) begin
                cycle(($urandom % 100) < pv, WIDTH'($urandom), ($urandom % 100) < pr);
            end
        end
        drain_all();

        // R1: reset mid-stream with beats held
        for (int i = 0; i < 3; i++) cycle(1'b1, WIDTH'(i + 1), 1'b0);
        rst = 1'b1;
        s_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_q.delete();
        prev_stall = 1'b0;
        chk(!m_valid && s_ready, "R1 reset empties", int'(m_valid), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule